// File: doc/BRIEF.md
# USB IN-Endpoint Status and Handshake Controller

This block keeps the status and handshake-decision state for a small USB device function with two IN endpoints. A USB serial engine sends it event strobes: a bus-reset detection, and a per-endpoint "data sent and ACK received" pulse. The block latches these events into sticky flags. Software reads the flags through a small register port and clears them by writing ones to a separate clear register. When an IN token arrives, the block decides from the endpoint's flag and its transmit-enable bit whether the engine sends data or answers NAK.

A detected bus reset goes one of two ways, chosen by a routing bit. With the bit at 0 it becomes a one-cycle reset request for the whole chip. With the bit at 1 it becomes a level interrupt. The bus-reset flag is cleared only by power-on reset. The endpoint flags and the control register are cleared by any reset, whether power-on or system reset.

The IN-token input carries a valid strobe and no ready signal, because the serial engine cannot be held off. The decision is always returned exactly one cycle after the token, flagged by `resp_valid`, and no back-pressure exists on either side. The register port is plain: a write strobe, an address and data. Read data is combinational from the address.

Top module: `usb_ep_status`

## Requirements
- R1: A pulse on `bus_reset_det` sets the bus-reset flag, which reads back as bit 0 of the status register (address 0) from the cycle after the pulse.
- R2: With the routing bit (bit 0 of the control register, address 2) at 0, `bus_reset_det` produces `rst_req` high for exactly the following cycle, and `irq` stays low.
- R3: With the routing bit at 1, `irq` is high whenever the bus-reset flag is set, and `bus_reset_det` does not raise `rst_req`.
- R4: The bus-reset flag clears only on power-on reset (`por_n` low) or on a write of 1 to bit 0 of the clear register (address 1). A system reset (`sys_rst_n` low) leaves it set.
- R5: A pulse on `ack_seen[k]` sets endpoint k's transmit flag, which reads back as status bit k+1 from the next cycle.
- R6: Writing 1 to clear-register bit k+1 clears endpoint k's flag. Writing 0 to a clear bit, or writing the status register at all, changes nothing. The clear register (address 1) and address 3 read as 0.
- R7: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: One cycle after `in_tok_valid`, `resp_valid` is 1 and `resp_ep` echoes the token's endpoint. `resp_data` is 1 only when that endpoint's flag was clear and its transmit-enable bit (control bit k+1) was 1 at the token. Otherwise `resp_data` is 0, meaning NAK.
- R9: A data response that gets no `ack_seen` leaves the flag clear, so the next IN token to that endpoint again gets data.
- R10: Any reset clears both endpoint flags, the control register, `resp_valid`, `resp_data` and `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 clear, 2 control |
| reg_wdata | input | NEP+1 | Register write data |
| reg_rdata | output | NEP+1 | Register read data for `reg_addr` |
| bus_reset_det | input | 1 | Bus reset line state detected (pulse) |
| ack_seen | input | NEP | Per-endpoint data sent and ACK received (pulse) |
| in_tok_valid | input | 1 | IN token received |
| in_tok_ep | input | EPW | Endpoint index of the IN token |
| resp_valid | output | 1 | Handshake decision valid |
| resp_data | output | 1 | 1 = send data, 0 = NAK |
| resp_ep | output | EPW | Endpoint index of the decision |
| irq | output | 1 | Bus-reset interrupt (level) |
| rst_req | output | 1 | Chip reset request (one-cycle pulse) |

## Verification
Every flag, the control register, `rst_req` and the token decision are each one register stage behind their inputs. The effect of inputs applied before a clock edge therefore shows on the outputs just after that edge. `irq` and `reg_rdata` are combinational from those registers and the current address, so they follow in the same sample. The bench applies stimulus one time unit after a rising edge, updates its model for that edge, and compares every output one time unit after the next edge, which keeps each check a single register stage from its cause.

// File: rtl/usb_ep_pkg.sv
`timescale 1ns/1ps
package usb_ep_pkg;
  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_CLR  = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_ep_flag.sv
`timescale 1ns/1ps
module usb_ep_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/usb_ep_regs.sv
`timescale 1ns/1ps
module usb_ep_regs #(
  parameter int NEP = 2,
  localparam int RW = NEP + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic [RW-1:0] status_i,
  output logic [RW-1:0] reg_rdata,
  output logic [RW-1:0] clr_o,
  output logic          route_o,
  output logic [NEP-1:0] txen_o
);
  import usb_ep_pkg::*;

  logic [RW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ctrl_q <= '0;
    else if (reg_we && reg_addr == 2'(A_CTRL))    ctrl_q <= reg_wdata;
  end

  assign clr_o   = (reg_we && reg_addr == 2'(A_CLR)) ? reg_wdata : '0;
  assign route_o = ctrl_q[0];
  assign txen_o  = ctrl_q[RW-1:1];

  always_comb begin
    case (reg_addr)
      2'(A_STAT): reg_rdata = status_i;
      2'(A_CTRL): reg_rdata = ctrl_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_resp.sv
`timescale 1ns/1ps
module usb_ep_resp #(
  parameter int NEP = 2,
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tok_valid,
  input  logic [EPW-1:0] tok_ep,
  input  logic [NEP-1:0] flags,
  input  logic [NEP-1:0] txen,
  output logic           resp_valid,
  output logic           resp_data,
  output logic [EPW-1:0] resp_ep
);
  logic ready_to_send;

  // an index beyond the last endpoint matches nothing and yields NAK
  always_comb begin
    ready_to_send = 1'b0;
    for (int k = 0; k < NEP; k++) begin
      if (tok_ep == EPW'(k)) ready_to_send = !flags[k] && txen[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= 1'b0;
      resp_ep    <= '0;
    end else begin
      resp_valid <= tok_valid;
      resp_data  <= tok_valid && ready_to_send;
      resp_ep    <= tok_ep;
    end
  end
endmodule

// File: rtl/usb_ep_status.sv
`timescale 1ns/1ps
module usb_ep_status #(
  parameter int NEP = 2,
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1,
  localparam int RW  = NEP + 1
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           sys_rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  input  logic           bus_reset_det,
  input  logic [NEP-1:0] ack_seen,
  input  logic           in_tok_valid,
  input  logic [EPW-1:0] in_tok_ep,
  output logic           resp_valid,
  output logic           resp_data,
  output logic [EPW-1:0] resp_ep,
  output logic           irq,
  output logic           rst_req
);
  logic           any_rst_n;
  logic [RW-1:0]  clr_vec;
  logic [RW-1:0]  status;
  logic           route;
  logic [NEP-1:0] txen;
  logic           rst_flag;
  logic [NEP-1:0] ep_flag;

  assign any_rst_n = por_n & sys_rst_n;

  // bus-reset flag: only power-on reset or an explicit clear removes it
  usb_ep_flag u_busrst (
    .clk(clk), .rst_n(por_n), .set_i(bus_reset_det),
    .clr_i(clr_vec[0]), .q_o(rst_flag)
  );

  for (genvar k = 0; k < NEP; k++) begin : g_ep
    usb_ep_flag u_txdone (
      .clk(clk), .rst_n(any_rst_n), .set_i(ack_seen[k]),
      .clr_i(clr_vec[k+1]), .q_o(ep_flag[k])
    );
  end

  assign status = {ep_flag, rst_flag};

  usb_ep_regs #(.NEP(NEP)) u_regs (
    .clk(clk), .rst_n(any_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_i(status), .reg_rdata(reg_rdata),
    .clr_o(clr_vec), .route_o(route), .txen_o(txen)
  );

  usb_ep_resp #(.NEP(NEP)) u_resp (
    .clk(clk), .rst_n(any_rst_n), .tok_valid(in_tok_valid),
    .tok_ep(in_tok_ep), .flags(ep_flag), .txen(txen),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_ep(resp_ep)
  );

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) rst_req <= 1'b0;
    else            rst_req <= bus_reset_det && !route;
  end

  assign irq = rst_flag && route;
endmodule

// File: rtl/usb_ep_status_chk.sv
`timescale 1ns/1ps
module usb_ep_status_chk #(
  parameter int NEP = 2,
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1,
  localparam int RW  = NEP + 1
) (
  input logic           clk,
  input logic           por_n,
  input logic           sys_rst_n,
  input logic           reg_we,
  input logic [1:0]     reg_addr,
  input logic [RW-1:0]  reg_wdata,
  input logic           bus_reset_det,
  input logic [NEP-1:0] ack_seen,
  input logic           in_tok_valid,
  input logic [EPW-1:0] in_tok_ep,
  input logic           rst_flag,
  input logic [NEP-1:0] ep_flag,
  input logic           route,
  input logic [NEP-1:0] txen,
  input logic           resp_valid,
  input logic           resp_data,
  input logic           irq,
  input logic           rst_req
);
  logic ctrl_wr, clr0_wr;
  assign ctrl_wr = reg_we && reg_addr == 2'd2;
  assign clr0_wr = reg_we && reg_addr == 2'd1 && reg_wdata[0];

  p_busrst_sets_r1: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    bus_reset_det |=> rst_flag);

  p_chip_route_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    bus_reset_det && !route |=> rst_req);

  p_irq_route_r3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    bus_reset_det && route && !ctrl_wr |=> irq && !rst_req);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    rst_flag && !clr0_wr |=> rst_flag);

  for (genvar k = 0; k < NEP; k++) begin : g_chk
    // R5 and R7: an ACK always leaves the flag set, whatever is written alongside
    p_ack_sets_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      ack_seen[k] |=> ep_flag[k]);
    p_no_ack_clear_r9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !ep_flag[k] && !ack_seen[k] |=> !ep_flag[k]);
    p_nak_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      in_tok_valid && in_tok_ep == EPW'(k) && (ep_flag[k] || !txen[k])
      |=> resp_valid && !resp_data);
  end

  p_resp_follows_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    in_tok_valid |=> resp_valid);
endmodule

bind usb_ep_status usb_ep_status_chk #(.NEP(NEP)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bus_reset_det(bus_reset_det),
  .ack_seen(ack_seen), .in_tok_valid(in_tok_valid), .in_tok_ep(in_tok_ep),
  .rst_flag(rst_flag), .ep_flag(ep_flag), .route(route), .txen(txen),
  .resp_valid(resp_valid), .resp_data(resp_data), .irq(irq), .rst_req(rst_req)
);

// File: tb/usb_ep_status_test.sv
`timescale 1ns/1ps
module usb_ep_status_test;
  localparam int NEP = 2;
  localparam int EPW = 1;
  localparam int RW  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic bus_reset_det = 1'b0;
  logic [NEP-1:0] ack_seen = '0;
  logic in_tok_valid = 1'b0;
  logic [EPW-1:0] in_tok_ep = '0;
  logic resp_valid, resp_data, irq, rst_req;
  logic [EPW-1:0] resp_ep;

  always #2.5 clk = ~clk;

  usb_ep_status #(.NEP(NEP)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_reset_det(bus_reset_det), .ack_seen(ack_seen),
    .in_tok_valid(in_tok_valid), .in_tok_ep(in_tok_ep),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_ep(resp_ep),
    .irq(irq), .rst_req(rst_req)
  );

  int total = 0, bad = 0;
  logic m_rflag = 0, m_route = 0, m_rv = 0, m_rd = 0, m_rq = 0;
  logic [NEP-1:0] m_eflag = '0, m_txen = '0;
  logic [EPW-1:0] m_rep = '0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] exp_rdata(logic [1:0] a);
    case (a)
      2'd0:    return {m_eflag, m_rflag};
      2'd2:    return {m_txen, m_route};
      default: return '0;
    endcase
  endfunction

  task automatic check_all();
    check("R1 R5 R6 readback", int'(reg_rdata), int'(exp_rdata(reg_addr)));
    check("R8 resp_valid", int'(resp_valid), int'(m_rv));
    check("R8 resp_data", int'(resp_data), int'(m_rd));
    if (m_rv) check("R8 resp_ep", int'(resp_ep), int'(m_rep));
    check("R2 rst_req", int'(rst_req), int'(m_rq));
    check("R3 irq", int'(irq), int'(m_rflag && m_route));
  endtask

  task automatic idle();
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    bus_reset_det = 0; ack_seen = 0; in_tok_valid = 0; in_tok_ep = 0;
  endtask

  // one clock: model the edge from the present inputs, then compare
  task automatic cycle();
    logic [RW-1:0] clr;
    logic n_rflag, n_route, n_rv, n_rd, n_rq;
    logic [NEP-1:0] n_eflag, n_txen;
    clr = (reg_we && reg_addr == 2'd1) ? reg_wdata : '0;
    n_rflag = bus_reset_det | (m_rflag & ~clr[0]);
    n_eflag = ack_seen | (m_eflag & ~clr[RW-1:1]);
    {n_txen, n_route} = (reg_we && reg_addr == 2'd2) ? reg_wdata : {m_txen, m_route};
    n_rv = in_tok_valid;
    n_rd = in_tok_valid && !m_eflag[in_tok_ep] && m_txen[in_tok_ep];
    n_rq = bus_reset_det && !m_route;
    @(posedge clk); #1;
    if (n_rv) m_rep = in_tok_ep;
    m_rflag = n_rflag; m_eflag = n_eflag; m_txen = n_txen; m_route = n_route;
    m_rv = n_rv; m_rd = n_rd; m_rq = n_rq;
    check_all();
  endtask

  task automatic apply_reset(bit power);
    @(posedge clk); #1;
    if (power) por_n = 0;
    sys_rst_n = 0;
    idle();
    repeat (2) @(posedge clk);
    #1;
    if (power) m_rflag = 0;
    m_eflag = 0; m_txen = 0; m_route = 0; m_rv = 0; m_rd = 0; m_rq = 0;
    check_all();
    por_n = 1; sys_rst_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [RW-1:0] d);
    idle(); reg_we = 1; reg_addr = a; reg_wdata = d; cycle(); idle();
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply_reset(1);
    // R10: everything low after power-on
    check("R10 reset status", int'(reg_rdata), 0);
    check("R10 reset rst_req", int'(rst_req), 0);

    // R1/R2: route 0, bus reset -> one-cycle request, no irq
    idle(); bus_reset_det = 1; cycle(); idle();
    check("R2 rst_req pulse", int'(rst_req), 1);
    check("R2 irq low", int'(irq), 0);
    check("R1 flag bit0", int'(reg_rdata[0]), 1);
    cycle();
    check("R2 pulse ends", int'(rst_req), 0);

    // R4/R6: status write and zero clear have no effect; sys reset keeps flag
    wr(2'd0, 3'b000);
    check("R6 status write ignored", int'(reg_rdata[0]), 1);
    wr(2'd1, 3'b000);
    reg_addr = 0; cycle();
    check("R4 zero clear ignored", int'(reg_rdata[0]), 1);
    apply_reset(0);
    idle(); cycle();
    check("R4 survives sys reset", int'(reg_rdata[0]), 1);
    wr(2'd1, 3'b001);
    cycle();
    check("R4 clear by write one", int'(reg_rdata[0]), 0);

    // R3: route 1
    wr(2'd2, 3'b111);
    bus_reset_det = 1; cycle(); idle();
    check("R3 irq high", int'(irq), 1);
    check("R3 no rst_req", int'(rst_req), 0);
    wr(2'd1, 3'b001);
    check("R3 irq drops on clear", int'(irq), 0);

    // R7: set wins against same-cycle clear
    ack_seen = 2'b01; reg_we = 1; reg_addr = 2'd1; reg_wdata = 3'b010; cycle(); idle();
    cycle();
    check("R7 set wins", int'(reg_rdata[1]), 1);

    // R8: ep0 flagged -> NAK, ep1 -> data
    in_tok_valid = 1; in_tok_ep = 0; cycle(); idle();
    check("R8 NAK on flag", int'(resp_data), 0);
    in_tok_valid = 1; in_tok_ep = 1; cycle(); idle();
    check("R8 data when armed", int'(resp_data), 1);
    // R9: no ACK, data again
    in_tok_valid = 1; in_tok_ep = 1; cycle(); idle();
    check("R9 data repeated", int'(resp_data), 1);
    // R8: disabled ep1 -> NAK
    wr(2'd2, 3'b011);
    in_tok_valid = 1; in_tok_ep = 1; cycle(); idle();
    check("R8 NAK when disabled", int'(resp_data), 0);

    // R10: system reset clears ep flags and control
    ack_seen = 2'b11; cycle(); idle();
    apply_reset(0);
    check("R10 ep flags cleared", int'(reg_rdata), int'(m_rflag));
    reg_addr = 2'd2; cycle();
    check("R10 control cleared", int'(reg_rdata), 0);

    // random traffic checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      idle();
      reg_addr      = 2'($urandom_range(0, 3));
      reg_we        = ($urandom_range(0, 2) == 0);
      reg_wdata     = RW'($urandom);
      bus_reset_det = ($urandom_range(0, 15) == 0);
      ack_seen      = NEP'($urandom) & NEP'($urandom);
      in_tok_valid  = ($urandom_range(0, 1) == 1);
      in_tok_ep     = EPW'($urandom);
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule